// File: doc/BRIEF.md
# Link Subsystem Reset Sequencer

This block builds the reset tree for a high-speed serial converter link subsystem. It merges three reset sources: an active-low push-button reset, an active-high software reset bit, and an active-low reset from the debug bridge. Their combination is the active-low management reset. From that point, a staged sequencer releases the downstream resets one group at a time. The core PLL reset goes first. The TX and RX register-interface resets follow, then the SYSREF generator reset, and the TX and RX link/transport resets come last. Each stage waits a programmable hold of `HOLD_CYCLES` clocks before the next one may start.

The SYSREF stage waits for the core PLL to report lock. Each link reset also needs lock, plus its own direction's active-low acknowledge. The two directions have separate gate instances, so one direction can stay in reset while the other runs. If lock is lost, the SYSREF and link resets reassert on the next edge, and sequencing restarts at the SYSREF stage. The PLL and register-interface resets are not re-run. The controller-block reset follows only the bridge reset, so the software bit and the push button cannot disturb the controller that drives the software bit.

All inputs are assumed synchronous to `clk`. All outputs are registered, so every output changes one edge after the input that causes the change.

Top module: `link_rst_seq`

## Requirements
- R1: `mgmt_rst_n` is low after any clock edge at which `glob_rst_n` is low, `sw_hw_rst` is high or `bridge_rst_n` is low. It is high after the first edge at which none of the three is active.
- R2: `pll_rst` is high whenever `mgmt_rst_n` is low. It falls after the `HOLD_CYCLES`-th edge, counting from the first edge with no reset source active.
- R3: `tx_reg_rst_n` and `rx_reg_rst_n` rise together after edge 2×`HOLD_CYCLES`, counting the same way as R2.
- R4: `sysref_rst_n` rises only after the register-interface resets are released, at the first later edge that samples `pll_locked` high. With lock already present, this is edge 2×`HOLD_CYCLES`+1.
- R5: `tx_link_rst_n` rises one edge after the SYSREF stage has held released and locked for `HOLD_CYCLES` edges, provided `pll_locked` is high and `tx_ack_n` is low. While `tx_ack_n` is high it stays low, and it rises at the first edge that samples `tx_ack_n` low.
- R6: `rx_link_rst_n` obeys the rule in R5 using `rx_ack_n`, and is independent of `tx_ack_n`.
- R7: An edge that samples `pll_locked` low drives `sysref_rst_n`, `tx_link_rst_n` and `rx_link_rst_n` low; `pll_rst`, `mgmt_rst_n` and the register resets keep their released state. When lock returns, the SYSREF release and a fresh hold of `HOLD_CYCLES` edges follow before the links release again. This holds even if lock was lost partway through a hold.
- R8: `ctrl_rst_n` equals `bridge_rst_n` delayed by one edge. `glob_rst_n` and `sw_hw_rst` have no effect on it.
- R9: From any stage, an edge that samples a reset source active leaves all of these asserted: `mgmt_rst_n` low, `pll_rst` high, both register resets low, `sysref_rst_n` low and both link resets low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| glob_rst_n | input | 1 | Push-button reset, active low |
| sw_hw_rst | input | 1 | Software hardware-reset bit, active high |
| bridge_rst_n | input | 1 | Debug-bridge reset, active low |
| pll_locked | input | 1 | Core PLL lock flag |
| tx_ack_n | input | 1 | TX reset acknowledge, active low |
| rx_ack_n | input | 1 | RX reset acknowledge, active low |
| mgmt_rst_n | output | 1 | Combined management reset, active low |
| ctrl_rst_n | output | 1 | Controller-block reset, active low |
| pll_rst | output | 1 | Core PLL reset, active high |
| tx_reg_rst_n | output | 1 | TX register-interface reset, active low |
| rx_reg_rst_n | output | 1 | RX register-interface reset, active low |
| sysref_rst_n | output | 1 | SYSREF generator reset, active low |
| tx_link_rst_n | output | 1 | TX link/transport reset, active low |
| rx_link_rst_n | output | 1 | RX link/transport reset, active low |

## Verification
Counting from the first edge with no source active, the release edges fall at 1, `HOLD_CYCLES`, 2×`HOLD_CYCLES`, 2×`HOLD_CYCLES`+1 and 3×`HOLD_CYCLES`+2. Reassertion from a source or from a loss of lock takes exactly one edge. The bench drives and samples one nanosecond after a rising edge, and it counts edges from the edge at which the stimulus is first seen. Each release is checked on the edge before it is due, where the reset must still be asserted, and on the edge where it is due. The links are checked with each acknowledge held off, and the sequence is checked with lock absent, with lock lost after a full bring-up, and with lock lost midway through the SYSREF hold.

// File: rtl/link_rst_pkg.sv
// Shared types for the link reset sequencer.
// Assumes nothing beyond a single sequencer clock.
package link_rst_pkg;

    // Sequencer stages, in release order.
    typedef enum logic [2:0] {
        ST_PLL_HOLD  = 3'd0,
        ST_REG_HOLD  = 3'd1,
        ST_SYS_WAIT  = 3'd2,
        ST_SYS_HOLD  = 3'd3,
        ST_LINK_RUN  = 3'd4
    } seq_stage_e;

endpackage

// File: rtl/link_rst_src_merge.sv
// Merges the three reset sources into the management reset.
// Also registers the controller reset from the bridge reset alone.
// Assumes all source inputs are synchronous to clk.
module link_rst_src_merge (
    input  logic clk,
    input  logic glob_rst_n,
    input  logic sw_hw_rst,
    input  logic bridge_rst_n,
    output logic src_active,
    output logic mgmt_rst_n,
    output logic ctrl_rst_n
);

    // Any source requesting reset.
    always_comb begin
        src_active = !glob_rst_n || sw_hw_rst || !bridge_rst_n;
    end

    // Register the management reset; asserts one edge after a source.
    always_ff @(posedge clk) begin
        mgmt_rst_n <= !src_active;
    end

    // Controller reset follows the bridge only.
    always_ff @(posedge clk) begin
        ctrl_rst_n <= bridge_rst_n;
    end

    assert_ctrl_isolated_R8: assert property (@(posedge clk)
        disable iff (!bridge_rst_n)
        $past(bridge_rst_n) |-> ctrl_rst_n);

endmodule

// File: rtl/link_rst_stage_seq.sv
// Staged release of the PLL, register-interface and SYSREF resets.
// Each stage holds HOLD_CYCLES edges. The SYSREF stage waits for lock,
// and a loss of lock sends the sequence back to the SYSREF wait.
// Assumes restart and pll_locked are synchronous to clk.
module link_rst_stage_seq
    import link_rst_pkg::*;
#(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic restart,
    input  logic pll_locked,
    output logic pll_rst,
    output logic reg_rst_n,
    output logic sysref_rst_n,
    output logic link_en
);

    localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);

    seq_stage_e       stage_q, stage_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hold_done;

    // Hold window end marker.
    always_comb begin
        hold_done = (cnt_q == HOLD_LAST);
    end

    // Next stage and hold counter.
    always_comb begin
        stage_d = stage_q;
        cnt_d   = cnt_q + 1'b1;
        unique case (stage_q)
            ST_PLL_HOLD: if (hold_done) begin
                stage_d = ST_REG_HOLD;
                cnt_d   = '0;
            end
            ST_REG_HOLD: if (hold_done) begin
                stage_d = ST_SYS_WAIT;
                cnt_d   = '0;
            end
            ST_SYS_WAIT: begin
                cnt_d = '0;
                if (pll_locked) stage_d = ST_SYS_HOLD;
            end
            ST_SYS_HOLD: begin
                if (!pll_locked) begin
                    stage_d = ST_SYS_WAIT;
                    cnt_d   = '0;
                end else if (hold_done) begin
                    stage_d = ST_LINK_RUN;
                    cnt_d   = '0;
                end
            end
            ST_LINK_RUN: begin
                cnt_d = '0;
                if (!pll_locked) stage_d = ST_SYS_WAIT;
            end
            default: begin
                stage_d = ST_PLL_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    // Stage register with synchronous restart.
    always_ff @(posedge clk) begin
        if (restart) begin
            stage_q <= ST_PLL_HOLD;
            cnt_q   <= '0;
        end else begin
            stage_q <= stage_d;
            cnt_q   <= cnt_d;
        end
    end

    // Decode reset levels from the current stage.
    always_comb begin
        pll_rst      = (stage_q == ST_PLL_HOLD);
        reg_rst_n    = (stage_q != ST_PLL_HOLD) && (stage_q != ST_REG_HOLD);
        sysref_rst_n = (stage_q == ST_SYS_HOLD) || (stage_q == ST_LINK_RUN);
        link_en      = (stage_q == ST_LINK_RUN);
    end

    assert_sysref_locked_R4: assert property (@(posedge clk)
        disable iff (restart)
        $rose(sysref_rst_n) |-> $past(pll_locked));

    assert_lock_loss_R7: assert property (@(posedge clk)
        disable iff (restart)
        !pll_locked |=> !sysref_rst_n);

endmodule

// File: rtl/link_rst_link_gate.sv
// Per-direction link/transport reset gate. It releases once the sequencer
// enables links, lock is present and the acknowledge is low. Lock loss or
// restart reasserts it on the next edge.
// Assumes inputs are synchronous to clk.
module link_rst_link_gate (
    input  logic clk,
    input  logic restart,
    input  logic link_en,
    input  logic pll_locked,
    input  logic ack_n,
    output logic link_rst_n
);

    // Release on acknowledge, hold until lock loss or restart.
    always_ff @(posedge clk) begin
        if (restart || !link_en || !pll_locked) begin
            link_rst_n <= 1'b0;
        end else if (!ack_n) begin
            link_rst_n <= 1'b1;
        end
    end

    // Covers the TX instance (R5) and the RX instance (R6).
    assert_link_gated_R5: assert property (@(posedge clk)
        disable iff (restart)
        $rose(link_rst_n) |-> $past(pll_locked && !ack_n && link_en));

    assert_link_lock_drop_R7: assert property (@(posedge clk)
        disable iff (restart)
        !pll_locked |=> !link_rst_n);

endmodule

// File: rtl/link_rst_seq.sv
// Top of the link subsystem reset sequencer. It merges the reset sources,
// runs the staged release and gates one link reset per direction on
// lock and that direction's acknowledge.
// Assumes every input is synchronous to clk.
module link_rst_seq #(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic glob_rst_n,
    input  logic sw_hw_rst,
    input  logic bridge_rst_n,
    input  logic pll_locked,
    input  logic tx_ack_n,
    input  logic rx_ack_n,
    output logic mgmt_rst_n,
    output logic ctrl_rst_n,
    output logic pll_rst,
    output logic tx_reg_rst_n,
    output logic rx_reg_rst_n,
    output logic sysref_rst_n,
    output logic tx_link_rst_n,
    output logic rx_link_rst_n
);

    localparam int NUM_DIR = 2;

    logic               src_active;
    logic               reg_rst_n;
    logic               link_en;
    logic [NUM_DIR-1:0] ack_vec_n;
    logic [NUM_DIR-1:0] link_vec_n;

    link_rst_src_merge u_merge (
        .clk          (clk),
        .glob_rst_n   (glob_rst_n),
        .sw_hw_rst    (sw_hw_rst),
        .bridge_rst_n (bridge_rst_n),
        .src_active   (src_active),
        .mgmt_rst_n   (mgmt_rst_n),
        .ctrl_rst_n   (ctrl_rst_n)
    );

    link_rst_stage_seq #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_seq (
        .clk          (clk),
        .restart      (src_active),
        .pll_locked   (pll_locked),
        .pll_rst      (pll_rst),
        .reg_rst_n    (reg_rst_n),
        .sysref_rst_n (sysref_rst_n),
        .link_en      (link_en)
    );

    // Direction 0 is TX, direction 1 is RX.
    always_comb begin
        ack_vec_n = {rx_ack_n, tx_ack_n};
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        link_rst_link_gate u_gate (
            .clk        (clk),
            .restart    (src_active),
            .link_en    (link_en),
            .pll_locked (pll_locked),
            .ack_n      (ack_vec_n[d]),
            .link_rst_n (link_vec_n[d])
        );
    end

    // Fan out the shared and per-direction resets.
    always_comb begin
        tx_reg_rst_n  = reg_rst_n;
        rx_reg_rst_n  = reg_rst_n;
        tx_link_rst_n = link_vec_n[0];
        rx_link_rst_n = link_vec_n[1];
    end

    assert_src_reset_all_R9: assert property (@(posedge clk)
        disable iff (!bridge_rst_n)
        (!glob_rst_n || sw_hw_rst) |=> (!mgmt_rst_n && pll_rst && !tx_reg_rst_n
            && !rx_reg_rst_n && !sysref_rst_n && !tx_link_rst_n && !rx_link_rst_n));

    assert_mgmt_pll_R2: assert property (@(posedge clk)
        disable iff (!glob_rst_n)
        !mgmt_rst_n |-> pll_rst);

    assert_sysref_order_R4: assert property (@(posedge clk)
        disable iff (!glob_rst_n)
        sysref_rst_n |-> (mgmt_rst_n && !pll_rst && tx_reg_rst_n));

    assert_link_order_R5: assert property (@(posedge clk)
        disable iff (!glob_rst_n)
        (tx_link_rst_n || rx_link_rst_n) |-> sysref_rst_n);

endmodule

// File: tb/link_rst_seq_tb_top.sv
`timescale 1ns/1ps
module link_rst_seq_tb_top;

    localparam int H = 16;

    logic clk = 1'b0;
    logic glob_rst_n = 1'b0;
    logic sw_hw_rst = 1'b0;
    logic bridge_rst_n = 1'b1;
    logic pll_locked = 1'b1;
    logic tx_ack_n = 1'b0;
    logic rx_ack_n = 1'b0;
    logic mgmt_rst_n, ctrl_rst_n, pll_rst, tx_reg_rst_n, rx_reg_rst_n;
    logic sysref_rst_n, tx_link_rst_n, rx_link_rst_n;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    link_rst_seq #(.HOLD_CYCLES(H)) dut_i (
        .clk(clk), .glob_rst_n(glob_rst_n), .sw_hw_rst(sw_hw_rst),
        .bridge_rst_n(bridge_rst_n), .pll_locked(pll_locked),
        .tx_ack_n(tx_ack_n), .rx_ack_n(rx_ack_n),
        .mgmt_rst_n(mgmt_rst_n), .ctrl_rst_n(ctrl_rst_n), .pll_rst(pll_rst),
        .tx_reg_rst_n(tx_reg_rst_n), .rx_reg_rst_n(rx_reg_rst_n),
        .sysref_rst_n(sysref_rst_n), .tx_link_rst_n(tx_link_rst_n),
        .rx_link_rst_n(rx_link_rst_n)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Advance n edges, then settle 1 ns past the edge.
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_all_asserted(input string req);
        chk(req, "mgmt_rst_n", mgmt_rst_n, 1'b0);
        chk(req, "pll_rst", pll_rst, 1'b1);
        chk(req, "tx_reg_rst_n", tx_reg_rst_n, 1'b0);
        chk(req, "rx_reg_rst_n", rx_reg_rst_n, 1'b0);
        chk(req, "sysref_rst_n", sysref_rst_n, 1'b0);
        chk(req, "tx_link_rst_n", tx_link_rst_n, 1'b0);
        chk(req, "rx_link_rst_n", rx_link_rst_n, 1'b0);
    endtask

    // Pulse the push button, release it, wait for links (lock, acks low).
    task automatic bring_up();
        glob_rst_n = 1'b0;
        edges(2);
        glob_rst_n = 1'b1;
        edges(3*H + 2);
    endtask

    task automatic t_reset_state();
        edges(2);
        chk_all_asserted("R9");
        chk("R8", "ctrl_rst_n in push reset", ctrl_rst_n, 1'b1);
    endtask

    task automatic t_startup();
        glob_rst_n = 1'b1;
        edges(1);
        chk("R1", "mgmt after release", mgmt_rst_n, 1'b1);
        edges(H - 2);
        chk("R2", "pll_rst edge H-1", pll_rst, 1'b1);
        edges(1);
        chk("R2", "pll_rst edge H", pll_rst, 1'b0);
        edges(H - 1);
        chk("R3", "tx_reg edge 2H-1", tx_reg_rst_n, 1'b0);
        edges(1);
        chk("R3", "tx_reg edge 2H", tx_reg_rst_n, 1'b1);
        chk("R3", "rx_reg edge 2H", rx_reg_rst_n, 1'b1);
        chk("R4", "sysref edge 2H", sysref_rst_n, 1'b0);
        edges(1);
        chk("R4", "sysref edge 2H+1", sysref_rst_n, 1'b1);
        edges(H);
        chk("R5", "tx_link edge 3H+1", tx_link_rst_n, 1'b0);
        chk("R6", "rx_link edge 3H+1", rx_link_rst_n, 1'b0);
        edges(1);
        chk("R5", "tx_link edge 3H+2", tx_link_rst_n, 1'b1);
        chk("R6", "rx_link edge 3H+2", rx_link_rst_n, 1'b1);
    endtask

    task automatic t_ack_gate();
        tx_ack_n = 1'b1;
        bring_up();
        chk("R6", "rx_link without tx ack", rx_link_rst_n, 1'b1);
        chk("R5", "tx_link held by ack", tx_link_rst_n, 1'b0);
        edges(10);
        chk("R5", "tx_link still held", tx_link_rst_n, 1'b0);
        tx_ack_n = 1'b0;
        edges(1);
        chk("R5", "tx_link on ack", tx_link_rst_n, 1'b1);
        rx_ack_n = 1'b1;
        bring_up();
        chk("R6", "rx_link held by ack", rx_link_rst_n, 1'b0);
        chk("R5", "tx_link without rx ack", tx_link_rst_n, 1'b1);
        rx_ack_n = 1'b0;
        edges(1);
        chk("R6", "rx_link on ack", rx_link_rst_n, 1'b1);
    endtask

    task automatic t_lock_wait();
        pll_locked = 1'b0;
        glob_rst_n = 1'b0;
        edges(2);
        glob_rst_n = 1'b1;
        edges(2*H + 5);
        chk("R3", "reg released without lock", tx_reg_rst_n, 1'b1);
        chk("R4", "sysref waits for lock", sysref_rst_n, 1'b0);
        pll_locked = 1'b1;
        edges(1);
        chk("R4", "sysref on lock", sysref_rst_n, 1'b1);
        edges(H);
        chk("R5", "tx_link hold after lock", tx_link_rst_n, 1'b0);
        edges(1);
        chk("R5", "tx_link after hold", tx_link_rst_n, 1'b1);
    endtask

    task automatic t_lock_drop();
        bring_up();
        pll_locked = 1'b0;
        edges(1);
        chk("R7", "sysref on lock loss", sysref_rst_n, 1'b0);
        chk("R7", "tx_link on lock loss", tx_link_rst_n, 1'b0);
        chk("R7", "rx_link on lock loss", rx_link_rst_n, 1'b0);
        chk("R7", "pll_rst stays released", pll_rst, 1'b0);
        chk("R7", "reg stays released", rx_reg_rst_n, 1'b1);
        chk("R7", "mgmt stays released", mgmt_rst_n, 1'b1);
        edges(4);
        pll_locked = 1'b1;
        edges(1);
        chk("R7", "sysref on lock return", sysref_rst_n, 1'b1);
        edges(5);
        pll_locked = 1'b0;
        edges(1);
        chk("R7", "sysref on mid-hold loss", sysref_rst_n, 1'b0);
        pll_locked = 1'b1;
        edges(1);
        chk("R7", "sysref after mid-hold return", sysref_rst_n, 1'b1);
        edges(H);
        chk("R7", "rx_link fresh hold", rx_link_rst_n, 1'b0);
        edges(1);
        chk("R7", "rx_link after fresh hold", rx_link_rst_n, 1'b1);
        chk("R7", "tx_link after fresh hold", tx_link_rst_n, 1'b1);
    endtask

    task automatic t_sources();
        sw_hw_rst = 1'b1;
        edges(1);
        chk_all_asserted("R9");
        chk("R8", "ctrl under sw reset", ctrl_rst_n, 1'b1);
        sw_hw_rst = 1'b0;
        edges(1);
        chk("R1", "mgmt after sw reset", mgmt_rst_n, 1'b1);
        edges(3*H + 1);
        chk("R5", "tx_link after sw restart", tx_link_rst_n, 1'b1);
        bridge_rst_n = 1'b0;
        edges(1);
        chk_all_asserted("R1");
        chk("R8", "ctrl follows bridge", ctrl_rst_n, 1'b0);
        bridge_rst_n = 1'b1;
        edges(1);
        chk("R8", "ctrl bridge release", ctrl_rst_n, 1'b1);
        chk("R1", "mgmt bridge release", mgmt_rst_n, 1'b1);
        edges(3*H + 1);
        glob_rst_n = 1'b0;
        edges(1);
        chk_all_asserted("R9");
        chk("R8", "ctrl under push reset", ctrl_rst_n, 1'b1);
        glob_rst_n = 1'b1;
        edges(1);
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_startup();
        t_ack_gate();
        t_lock_wait();
        t_lock_drop();
        t_sources();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule